// File: doc/BRIEF.md
# Paged Address Mapping Unit

This block turns the 16-bit address of an 8-bit processor into an 18-bit global address that spans a 256K memory. The top five bits of the processor address choose one of thirty-two page registers. The 7-bit contents of that register replace those five bits as global address bits 17 down to 11. The low eleven bits go through unchanged, so each register names one of 128 pages of 2K.

Software reprograms a page register with a single-cycle I/O write strobe. The register index comes from the low five bits of the I/O port address, and the value comes from the low seven bits of the data byte. The thirty-two registers sit in two banks of sixteen, and the top index bit chooses the bank.

A second processor already drives a full 18-bit address. When it is active, its address skips translation. A final selector chooses between the processor-side address and a video-side address.

Top module: `page_map_unit`

## Requirements
- R1: After reset, register i holds i for every i from 0 to 31. The translated output is therefore {2'b00, cpuAddr} until software writes a register.
- R2: When cpuSel=0 and videoSel=0, globalAddr[17:11] equals the contents of the register indexed by cpuAddr[15:11]. Translation is combinational.
- R3: When cpuSel=0 and videoSel=0, globalAddr[10:0] equals cpuAddr[10:0].
- R4: When ioWrStb=1 at a rising clock edge, the register indexed by ioPortAddr[4:0] takes ioData[6:0]. The new value shows on the output from that edge onward. ioPortAddr[7:5] has no effect.
- R5: Bit 7 of ioData is never stored.
- R6: When ioWrStb=0, changes on ioPortAddr and ioData leave every register unchanged.
- R7: Index bit 4 selects the bank. A write to index k+16 leaves index k unchanged, and the reverse also holds.
- R8: When cpuSel=1 and videoSel=0, globalAddr equals nativeAddr.
- R9: When videoSel=1, globalAddr equals videoAddr for either value of cpuSel.
- R10: Register writes take effect whatever the values of cpuSel and videoSel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrStb | input | 1 | Single-cycle register write strobe |
| ioPortAddr | input | 8 | I/O port address; bits 4:0 give the register index |
| ioData | input | 8 | Write data; bits 6:0 are stored |
| cpuAddr | input | 16 | 8-bit processor address |
| nativeAddr | input | 18 | Address from the processor that drives 18 bits |
| cpuSel | input | 1 | 1 selects the native 18-bit processor |
| videoSel | input | 1 | 1 selects the video address |
| videoAddr | input | 18 | Video subsystem address |
| globalAddr | output | 18 | Global memory address |

## Verification
The directed cases go after the bank split by writing index pairs k and k+16. A design that decodes the bank wrongly would overwrite the partner register.

Other directed cases write data bytes with bit 7 set. A design that keeps too many bits would leak bit 7 into the mapped page.

Further cases change the port address and data while the strobe is low, and write while video or the native processor is selected. These expose a write path that ignores the strobe or that is gated by the selects.

Random traffic then compares each translated address with a shadow copy of the registers, and checks the selector priority on every cycle.

// File: rtl/pam_pkg.sv
package pam_pkg;
  parameter int CPU_AW   = 16;
  parameter int GLOB_AW  = 18;
  parameter int OFF_W    = 11;
  parameter int MAP_W    = GLOB_AW - OFF_W;
  parameter int IDX_W    = CPU_AW - OFF_W;
  parameter int ROW_W    = IDX_W - 1;
  parameter int NUM_BANK = 2;
  parameter int DATA_W   = 8;
  parameter int PORT_W   = 8;

  typedef enum logic [1:0] {
    SRC_MAPPED = 2'd0,
    SRC_NATIVE = 2'd1,
    SRC_VIDEO  = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic [NUM_BANK-1:0] bankWr;
    logic [ROW_W-1:0]    row;
    logic [MAP_W-1:0]    data;
    srcSel_e             src;
  } mapStrobes_t;
endpackage

// File: rtl/pam_ctrl.sv
module pam_ctrl
  import pam_pkg::*;
(
  input  logic              ioWrStb,
  input  logic [PORT_W-1:0] ioPortAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              cpuSel,
  input  logic              videoSel,
  output mapStrobes_t       strobes
);
  logic [IDX_W-1:0] wrIdx;
  assign wrIdx = ioPortAddr[IDX_W-1:0];

  always_comb begin
    strobes = '0;
    strobes.row  = wrIdx[ROW_W-1:0];
    strobes.data = ioData[MAP_W-1:0];
    // top index bit and its inverse enable alternate banks
    strobes.bankWr[0] = ioWrStb & ~wrIdx[IDX_W-1];
    strobes.bankWr[1] = ioWrStb &  wrIdx[IDX_W-1];
    if (videoSel)    strobes.src = SRC_VIDEO;
    else if (cpuSel) strobes.src = SRC_NATIVE;
    else             strobes.src = SRC_MAPPED;
  end
endmodule

// File: rtl/pam_datapath.sv
module pam_datapath
  import pam_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobes_t        strobes,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [GLOB_AW-1:0] nativeAddr,
  input  logic [GLOB_AW-1:0] videoAddr,
  output logic [GLOB_AW-1:0] globalAddr
);
  localparam int BANK_ROWS = 2 ** ROW_W;

  logic [MAP_W-1:0] bankRd [NUM_BANK];
  logic [ROW_W-1:0] rdRow;
  logic [MAP_W-1:0] mapped;
  logic [GLOB_AW-1:0] xlatAddr;

  assign rdRow = cpuAddr[CPU_AW-2:OFF_W];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [MAP_W-1:0] mem [BANK_ROWS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < BANK_ROWS; r++)
          mem[r] <= MAP_W'(b * BANK_ROWS + r);
      end else if (strobes.bankWr[b]) begin
        mem[strobes.row] <= strobes.data;
      end
    end
    assign bankRd[b] = mem[rdRow];
  end

  assign mapped   = cpuAddr[CPU_AW-1] ? bankRd[1] : bankRd[0];
  assign xlatAddr = {mapped, cpuAddr[OFF_W-1:0]};

  always_comb begin
    unique case (strobes.src)
      SRC_VIDEO:  globalAddr = videoAddr;
      SRC_NATIVE: globalAddr = nativeAddr;
      default:    globalAddr = xlatAddr;
    endcase
  end
endmodule

// File: rtl/page_map_unit.sv
module page_map_unit
  import pam_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioWrStb,
  input  logic [PORT_W-1:0]  ioPortAddr,
  input  logic [DATA_W-1:0]  ioData,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [GLOB_AW-1:0] nativeAddr,
  input  logic               cpuSel,
  input  logic               videoSel,
  input  logic [GLOB_AW-1:0] videoAddr,
  output logic [GLOB_AW-1:0] globalAddr
);
  mapStrobes_t strobes;

  pam_ctrl u_ctrl (
    .ioWrStb(ioWrStb), .ioPortAddr(ioPortAddr), .ioData(ioData),
    .cpuSel(cpuSel), .videoSel(videoSel), .strobes(strobes)
  );

  pam_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .nativeAddr(nativeAddr), .videoAddr(videoAddr), .globalAddr(globalAddr)
  );
endmodule

// File: rtl/pam_checker.sv
module pam_checker
  import pam_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ioWrStb,
  input logic [PORT_W-1:0]  ioPortAddr,
  input logic [DATA_W-1:0]  ioData,
  input logic [CPU_AW-1:0]  cpuAddr,
  input logic [GLOB_AW-1:0] nativeAddr,
  input logic               cpuSel,
  input logic               videoSel,
  input logic [GLOB_AW-1:0] videoAddr,
  input logic [GLOB_AW-1:0] globalAddr
);
  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuSel && !videoSel) |-> globalAddr[OFF_W-1:0] == cpuAddr[OFF_W-1:0]);

  // R8
  native_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !videoSel) |-> globalAddr == nativeAddr);

  // R9
  video_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    videoSel |-> globalAddr == videoAddr);

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ioWrStb) && !cpuSel && !videoSel
      && cpuAddr[CPU_AW-1:OFF_W] == $past(ioPortAddr[IDX_W-1:0]))
    |-> globalAddr[GLOB_AW-1:OFF_W] == $past(ioData[MAP_W-1:0]));

  // R6
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ioWrStb) && $stable(cpuAddr) && !cpuSel && !videoSel
      && !$past(cpuSel) && !$past(videoSel))
    |-> $stable(globalAddr));
endmodule

bind page_map_unit pam_checker u_pam_checker (
  .clk(clk), .rstN(rstN), .ioWrStb(ioWrStb), .ioPortAddr(ioPortAddr),
  .ioData(ioData), .cpuAddr(cpuAddr), .nativeAddr(nativeAddr),
  .cpuSel(cpuSel), .videoSel(videoSel), .videoAddr(videoAddr),
  .globalAddr(globalAddr)
);

// File: tb/test_page_map_unit.sv
module test_page_map_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        ioWrStb = 0;
  logic [7:0]  ioPortAddr = 0;
  logic [7:0]  ioData = 0;
  logic [15:0] cpuAddr = 0;
  logic [17:0] nativeAddr = 0;
  logic        cpuSel = 0;
  logic        videoSel = 0;
  logic [17:0] videoAddr = 0;
  logic [17:0] globalAddr;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;
  logic [6:0] shadow [32];

  always #4 clk = ~clk;

  page_map_unit i_page_map_unit (
    .clk(clk), .rstN(rstN), .ioWrStb(ioWrStb), .ioPortAddr(ioPortAddr),
    .ioData(ioData), .cpuAddr(cpuAddr), .nativeAddr(nativeAddr),
    .cpuSel(cpuSel), .videoSel(videoSel), .videoAddr(videoAddr),
    .globalAddr(globalAddr)
  );

  function automatic logic [17:0] expAddr(logic [15:0] a, logic [17:0] nat,
                                          logic [17:0] vid, logic cs, logic vs);
    if (vs) return vid;
    if (cs) return nat;
    return {shadow[a[15:11]], a[10:0]};
  endfunction

  task automatic check(string req);
    logic [17:0] e;
    e = expAddr(cpuAddr, nativeAddr, videoAddr, cpuSel, videoSel);
    nTests++;
    if (globalAddr !== e) begin
      nFail++;
      $display("FAIL %s: got %h expected %h (cpuAddr=%h cs=%0b vs=%0b)",
               req, globalAddr, e, cpuAddr, cpuSel, videoSel);
    end
  endtask

  // drive at negedge, write lands on the next posedge, return at the following negedge
  task automatic writeReg(logic [7:0] port, logic [7:0] data);
    ioPortAddr = port;
    ioData     = data;
    ioWrStb    = 1;
    @(negedge clk);
    ioWrStb = 0;
    shadow[port[4:0]] = data[6:0];
  endtask

  task automatic lookup(logic [15:0] a, string req);
    cpuSel = 0; videoSel = 0; cpuAddr = a;
    #1 check(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) shadow[i] = 7'(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset identity, R2 and R3 along the way
    for (int i = 0; i < 32; i++) lookup({5'(i), 11'h5A5 ^ 11'(i)}, "R1");
    lookup(16'hFFFF, "R3");

    // R4 write plus R5 bit 7 dropped
    writeReg(8'h03, 8'hFF);
    lookup(16'h1BCD, "R5");
    writeReg(8'hE7, 8'h85);   // upper port bits ignored
    lookup(16'h3800, "R4");
    lookup(16'h3FFF, "R2");

    // R7 bank split
    writeReg(8'h02, 8'h11);
    writeReg(8'h12, 8'h22);
    lookup(16'h1000, "R7");
    lookup(16'h9000, "R7");
    writeReg(8'h1F, 8'h7E);
    lookup(16'h7800, "R7");
    lookup(16'hF800, "R7");

    // R6 no strobe, busy port/data
    for (int i = 0; i < 5; i++) begin
      ioPortAddr = 8'($urandom); ioData = 8'($urandom);
      @(negedge clk);
    end
    for (int i = 0; i < 32; i++) lookup({5'(i), 11'h0}, "R6");

    // R8, R9 selects
    nativeAddr = 18'h2ABCD; videoAddr = 18'h15432;
    cpuAddr = 16'h4321; cpuSel = 1; videoSel = 0; #1 check("R8");
    cpuSel = 1; videoSel = 1; #1 check("R9");
    cpuSel = 0; videoSel = 1; #1 check("R9");

    // R10 writes under other selects
    @(negedge clk);
    videoSel = 1; writeReg(8'h08, 8'h3C);
    videoSel = 0; cpuSel = 1; writeReg(8'h19, 8'h4D);
    lookup(16'h4000, "R10");
    lookup(16'hC800, "R10");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        cpuSel = 1'($urandom); videoSel = 1'($urandom);
        writeReg(8'($urandom), 8'($urandom));
      end else begin
        cpuAddr    = 16'($urandom);
        nativeAddr = 18'($urandom);
        videoAddr  = 18'($urandom);
        cpuSel     = ($urandom_range(0, 3) == 0);
        videoSel   = ($urandom_range(0, 4) == 0);
        #1 check(videoSel ? "R9" : (cpuSel ? "R8" : "R2"));
        @(negedge clk);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule